// File: doc/BRIEF.md
# Supply and Thermal Enable Guard

This block sits between a serial-bus switch controller and the gate drivers of two power switches. It watches a digital supply-good flag from an undervoltage comparator and an 8-bit die temperature code. It holds the bus controller in reset, with both gate enables low, until the supply has been good for a qualification window. While the block runs, it passes the controller's latched switch commands through to the gate drivers.

Short supply dips are filtered out. Only a dropout that lasts for a minimum number of cycles re-arms the reset and starts a new qualification window. A thermal trip with hysteresis forces both enables low at the same time. When the die cools enough, the enables return to whatever the controller currently holds, and no new bus transaction is needed.

Both windows are counted in cycles of the block clock. They are derived from a clock-frequency parameter, which defaults to 1 MHz. At that frequency the qualification window is 300 cycles and the dropout window is 100 cycles.

Top module: `supply_fault_guard`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `bus_rst` is 1 and `gate_en` is 0.
- R2: Whenever `bus_rst` is 1, `gate_en` is 0, whatever the value of `cmd_en`.
- R3: After reset, `bus_rst` falls right after the clock edge that samples `supply_ok` high for the 300th consecutive time. A single low sample restarts the count from zero.
- R4: While running, `bus_rst` rises right after the edge that samples `supply_ok` low for the 100th consecutive time. A run of 99 or fewer low samples changes neither `bus_rst` nor `gate_en`.
- R5: A sampled `die_temp` of 120 or more drives both bits of `gate_en` to 0 from the following cycle onwards.
- R6: Once tripped, the block keeps `gate_en` at 0 while the sampled `die_temp` stays above 105. After the edge that samples a value of 105 or less, `gate_en` again equals the current `cmd_en`. A value from 106 to 119 does not trip a block that is not tripped.
- R7: While the block runs and is not tripped, `gate_en` equals `cmd_en` bit for bit in the same cycle. Bit 0 drives switch 0 and bit 1 drives switch 1.
- R8: After a dropout has re-armed the reset, a complete new run of 300 consecutive high samples is needed before `bus_rst` falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, 1 MHz by default |
| rst | input | 1 | Synchronous active-high reset, applied at power-up |
| supply_ok | input | 1 | Supply-good flag from the undervoltage comparator, 1 = good |
| die_temp | input | 8 | Unsigned die temperature in whole degrees Celsius |
| cmd_en | input | 2 | Latched switch commands from the bus controller |
| bus_rst | output | 1 | Reset to the bus controller, 1 = held in reset |
| gate_en | output | 2 | Gated enables to the two gate drivers |

## Verification
The assertions rely on `supply_ok` and `die_temp` already being clean and synchronous to `clk`, because the comparator and the temperature sensor own the analog hysteresis and any synchronization. They also rely on `cmd_en` changing only between edges. The stimulus therefore drives every input just after the falling clock edge and reads outputs one full half-period later. Temperatures are drawn mostly from a band around the trip and release points, so the hysteresis region is crossed often. Supply dips are drawn with lengths strictly below the dropout window, except in the directed cases that sit exactly on the window boundaries.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;

    typedef enum logic {
        SG_HOLD = 1'b0,
        SG_RUN  = 1'b1
    } sg_state_e;

    typedef struct packed {
        logic run;
        logic hot;
    } sg_verdict_t;

    function automatic int unsigned sg_cycles(input int unsigned clk_hz,
                                              input int unsigned usec);
        return ((clk_hz / 1000) * usec) / 1000;
    endfunction

    function automatic logic sg_next_hot(input logic        hot_now,
                                         input int unsigned temp,
                                         input int unsigned trip,
                                         input int unsigned release_at);
        if (temp >= trip)
            return 1'b1;
        else if (temp <= release_at)
            return 1'b0;
        else
            return hot_now;
    endfunction

endpackage

// File: rtl/sg_supply_qual.sv
module sg_supply_qual
    import supply_guard_pkg::*;
#(
    parameter int unsigned ARM_CYC  = 300,
    parameter int unsigned DROP_CYC = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    output logic run
);
    localparam int unsigned MAX_CYC = (ARM_CYC > DROP_CYC) ? ARM_CYC : DROP_CYC;
    localparam int unsigned CW      = $clog2(MAX_CYC + 1);
    localparam logic [CW-1:0] ARM_LAST  = CW'(ARM_CYC - 1);
    localparam logic [CW-1:0] DROP_LAST = CW'(DROP_CYC - 1);

    sg_state_e     state;
    logic [CW-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SG_HOLD;
            run_len <= '0;
        end else begin
            unique case (state)
                SG_HOLD: begin
                    if (!supply_ok) begin
                        run_len <= '0;
                    end else if (run_len == ARM_LAST) begin
                        state   <= SG_RUN;
                        run_len <= '0;
                    end else begin
                        run_len <= run_len + 1'b1;
                    end
                end
                SG_RUN: begin
                    if (supply_ok) begin
                        run_len <= '0;
                    end else if (run_len == DROP_LAST) begin
                        state   <= SG_HOLD;
                        run_len <= '0;
                    end else begin
                        run_len <= run_len + 1'b1;
                    end
                end
                default: begin
                    state   <= SG_HOLD;
                    run_len <= '0;
                end
            endcase
        end
    end

    assign run = (state == SG_RUN);

endmodule

// File: rtl/sg_therm_guard.sv
module sg_therm_guard
    import supply_guard_pkg::*;
#(
    parameter int unsigned TEMP_W    = 8,
    parameter int unsigned TRIP_C    = 120,
    parameter int unsigned HYST_C    = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TEMP_W-1:0] die_temp,
    output logic              hot
);
    localparam int unsigned RELEASE_C = TRIP_C - HYST_C;

    always_ff @(posedge clk) begin
        if (rst)
            hot <= 1'b0;
        else
            hot <= sg_next_hot(hot, int'(die_temp), TRIP_C, RELEASE_C);
    end

endmodule

// File: rtl/sg_gate_mask.sv
module sg_gate_mask
    import supply_guard_pkg::*;
#(
    parameter int unsigned NUM_SW = 2
) (
    input  sg_verdict_t       verdict,
    input  logic [NUM_SW-1:0] cmd_en,
    output logic [NUM_SW-1:0] gate_en
);
    logic allow;

    assign allow = verdict.run & ~verdict.hot;

    for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
        assign gate_en[i] = allow & cmd_en[i];
    end

endmodule

// File: rtl/supply_fault_guard.sv
module supply_fault_guard
    import supply_guard_pkg::*;
#(
    parameter int unsigned CLK_HZ  = 1_000_000,
    parameter int unsigned ARM_US  = 300,
    parameter int unsigned DROP_US = 100,
    parameter int unsigned TEMP_W  = 8,
    parameter int unsigned TRIP_C  = 120,
    parameter int unsigned HYST_C  = 15,
    parameter int unsigned NUM_SW  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              supply_ok,
    input  logic [TEMP_W-1:0] die_temp,
    input  logic [NUM_SW-1:0] cmd_en,
    output logic              bus_rst,
    output logic [NUM_SW-1:0] gate_en
);
    localparam int unsigned ARM_CYC  = sg_cycles(CLK_HZ, ARM_US);
    localparam int unsigned DROP_CYC = sg_cycles(CLK_HZ, DROP_US);

    sg_verdict_t verdict;

    sg_supply_qual #(
        .ARM_CYC  (ARM_CYC),
        .DROP_CYC (DROP_CYC)
    ) u_qual (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .run       (verdict.run)
    );

    sg_therm_guard #(
        .TEMP_W (TEMP_W),
        .TRIP_C (TRIP_C),
        .HYST_C (HYST_C)
    ) u_therm (
        .clk      (clk),
        .rst      (rst),
        .die_temp (die_temp),
        .hot      (verdict.hot)
    );

    sg_gate_mask #(
        .NUM_SW (NUM_SW)
    ) u_mask (
        .verdict (verdict),
        .cmd_en  (cmd_en),
        .gate_en (gate_en)
    );

    assign bus_rst = ~verdict.run;

endmodule

// File: rtl/supply_fault_guard_chk.sv
module supply_fault_guard_chk #(
    parameter int unsigned ARM_CYC  = 300,
    parameter int unsigned DROP_CYC = 100,
    parameter int unsigned TEMP_W   = 8,
    parameter int unsigned TRIP_C   = 120,
    parameter int unsigned NUM_SW   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              supply_ok,
    input logic [TEMP_W-1:0] die_temp,
    input logic [NUM_SW-1:0] cmd_en,
    input logic              bus_rst,
    input logic [NUM_SW-1:0] gate_en
);
    localparam int unsigned MAX_CYC = (ARM_CYC > DROP_CYC) ? ARM_CYC : DROP_CYC;
    localparam int unsigned CW      = $clog2(MAX_CYC + 1);

    logic [CW-1:0] hi_run;
    logic [CW-1:0] lo_run;

    always_ff @(posedge clk) begin
        if (rst || !supply_ok)
            hi_run <= '0;
        else if (hi_run != CW'(MAX_CYC))
            hi_run <= hi_run + 1'b1;
        if (rst || supply_ok)
            lo_run <= '0;
        else if (lo_run != CW'(MAX_CYC))
            lo_run <= lo_run + 1'b1;
    end

    AST_OFF_IN_RESET: assert property (@(posedge clk) disable iff (rst)
        bus_rst |-> (gate_en == '0));                                   // R2

    AST_ARM_WINDOW: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_rst) |-> (hi_run >= CW'(ARM_CYC)));                   // R3

    AST_DROP_WINDOW: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_rst) |-> (lo_run >= CW'(DROP_CYC)));                  // R4

    AST_HOT_CUTOFF: assert property (@(posedge clk) disable iff (rst)
        ($past(die_temp) >= TEMP_W'(TRIP_C)) |-> (gate_en == '0));      // R5

    AST_NO_SPURIOUS_EN: assert property (@(posedge clk) disable iff (rst)
        ((gate_en & ~cmd_en) == '0));                                   // R7

endmodule

bind supply_fault_guard supply_fault_guard_chk #(
    .ARM_CYC  (ARM_CYC),
    .DROP_CYC (DROP_CYC),
    .TEMP_W   (TEMP_W),
    .TRIP_C   (TRIP_C),
    .NUM_SW   (NUM_SW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .supply_ok (supply_ok),
    .die_temp  (die_temp),
    .cmd_en    (cmd_en),
    .bus_rst   (bus_rst),
    .gate_en   (gate_en)
);

// File: tb/sim_supply_fault_guard.sv
`timescale 1ns/1ps
module sim_supply_fault_guard;

    logic       clk = 1'b0;
    logic       rst;
    logic       supply_ok;
    logic [7:0] die_temp;
    logic [1:0] cmd_en;
    logic       bus_rst;
    logic [1:0] gate_en;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    supply_fault_guard u0 (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .die_temp  (die_temp),
        .cmd_en    (cmd_en),
        .bus_rst   (bus_rst),
        .gate_en   (gate_en)
    );

    function automatic bit next_hot(input bit hot, input int t);
        if (t >= 120) return 1'b1;
        if (t <= 105) return 1'b0;
        return hot;
    endfunction

    function automatic int exp_gate(input bit hot, input int cmd);
        return hot ? 0 : cmd;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit hot_m;
        void'($urandom(32'd20240611));
        rst = 1'b1; supply_ok = 1'b0; die_temp = 8'd25; cmd_en = 2'b00;
        step(3);
        chk("R1 bus_rst in reset", bus_rst, 1);
        cmd_en = 2'b11; supply_ok = 1'b1;
        step(2);
        chk("R1 gate_en in reset", gate_en, 0);

        // Release reset, qualify with one glitch mid-window
        rst = 1'b0;
        step(1);
        chk("R1 bus_rst first cycle after reset", bus_rst, 1);
        step(149);
        chk("R2 gate off while held", gate_en, 0);
        supply_ok = 1'b0;
        step(1);
        supply_ok = 1'b1;
        step(299);
        chk("R3 still held after 299 good samples", bus_rst, 1);
        chk("R2 gate off at window end", gate_en, 0);
        step(1);
        chk("R3 released after 300 good samples", bus_rst, 0);

        // R7 combinational pass-through
        for (int c = 0; c < 4; c++) begin
            cmd_en = 2'(c);
            #1;
            chk("R7 gate follows cmd", gate_en, c);
            step(1);
        end

        // R4 short dips
        cmd_en = 2'b10;
        supply_ok = 1'b0;
        step(99);
        chk("R4 99-cycle dip ignored bus_rst", bus_rst, 0);
        chk("R4 99-cycle dip ignored gate", gate_en, 2);
        supply_ok = 1'b1;
        step(1);
        for (int k = 0; k < 20; k++) begin
            int len = $urandom_range(1, 99);
            supply_ok = 1'b0;
            step(len);
            chk("R4 random short dip bus_rst", bus_rst, 0);
            supply_ok = 1'b1;
            step($urandom_range(1, 5));
            chk("R4 random short dip gate", gate_en, 2);
        end

        // R4 full dropout
        supply_ok = 1'b0;
        step(99);
        chk("R4 held running at 99 low", bus_rst, 0);
        step(1);
        chk("R4 re-armed at 100 low", bus_rst, 1);
        chk("R2 gate off after re-arm", gate_en, 0);

        // R8 full new window
        supply_ok = 1'b1;
        step(299);
        chk("R8 held after 299 good", bus_rst, 1);
        step(1);
        chk("R8 released after 300 good", bus_rst, 0);

        // R5 / R6 directed
        cmd_en = 2'b11; die_temp = 8'd119;
        step(1);
        chk("R6 119 does not trip", gate_en, 3);
        die_temp = 8'd120;
        step(1);
        chk("R5 trip at 120", gate_en, 0);
        die_temp = 8'd110;
        step(1);
        chk("R6 held off at 110", gate_en, 0);
        die_temp = 8'd106;
        step(1);
        chk("R6 held off at 106", gate_en, 0);
        cmd_en = 2'b01;
        step(1);
        chk("R6 held off with new cmd", gate_en, 0);
        die_temp = 8'd105;
        step(1);
        chk("R6 release at 105 to current cmd", gate_en, 1);
        die_temp = 8'd119;
        step(1);
        chk("R6 no retrip below 120", gate_en, 1);
        die_temp = 8'd255;
        step(1);
        chk("R5 trip at 255", gate_en, 0);
        die_temp = 8'd0;
        step(1);
        chk("R6 release at 0", gate_en, 1);

        // Random thermal sweep against reference model
        hot_m = 1'b0;
        for (int k = 0; k < 2000; k++) begin
            int t = $urandom_range(90, 135);
            int c = $urandom_range(0, 3);
            die_temp = 8'(t);
            cmd_en   = 2'(c);
            step(1);
            hot_m = next_hot(hot_m, t);
            chk(hot_m ? "R5 random hot" : "R6 random cool", gate_en, exp_gate(hot_m, c));
        end

        // R1 again: reset mid-run
        rst = 1'b1;
        step(1);
        chk("R1 reset mid-run bus_rst", bus_rst, 1);
        chk("R1 reset mid-run gate", gate_en, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule